// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI master that software drives through seven 32-bit registers. Four data words together hold a 128-bit shift field. A control word sets the transfer length, the bit order, the SCLK edge that updates MOSI and the SCLK edge that samples MISO. It also holds an interrupt enable, a mode that gates the slave selects by activity, and a start bit. A divider register sets the SCLK rate, and a select register chooses which of the active-low slave-select lines are driven.

Setting the start bit runs a transfer of N bits, where N is taken from the control word. Bit positions count from the low end of the 128-bit field, and word 0 holds bits 31:0. As each bit is sampled from MISO, it overwrites the bit that was sent from the same position. After the transfer, the data words therefore hold the reply. While a transfer runs, the block accepts only writes to the select register.

Top module: `spi_regmaster`

## Requirements
- R1: Register word index `reg_addr[4:2]` maps as follows. Indices 0..3 are data words, with word w holding field bits 32w+31..32w. Index 4 is control, index 5 is the divider and index 6 is the slave select. Control reads back as {18'b0, ss_gate[13], irq_en[12], lsb_first[11], drive_fall[10], sample_fall[9], busy[8], 1'b0, len[6:0]}. The other indices read 0.
- R2: A write to control with bit 8 set starts a transfer when the block is idle. Bit 8 reads 1 from the next cycle for exactly 2*N*(DIV+1) cycles.
- R3: N equals control bits 6:0, and a value of 0 means 128. Only field bits N-1..0 take part in the transfer.
- R4: SCLK is low when idle. It toggles every DIV+1 cycles during a transfer, with the first rising edge DIV+1 cycles after the start, and ends low.
- R5: When bit 10 is clear, MOSI changes after rising SCLK edges. When it is set, MOSI changes after falling edges. In both cases the first bit is on MOSI from the start. MOSI is 0 when idle.
- R6: When bit 9 is clear, MISO is captured on rising SCLK edges. When it is set, MISO is captured on falling edges. Bit k of the transfer is captured on the k-th edge of the chosen kind.
- R7: When bit 11 is set, transfer bit k uses field position k. When it is clear, transfer bit k uses position N-1-k.
- R8: Each captured bit replaces the field bit at its own position. Field bits at N and above keep their values.
- R9: `ss_n` is the complement of the select register. When bit 13 is set, the selected lines go low only while busy.
- R10: When bit 12 is set, `irq` rises as the transfer ends and stays high until the next write to control.
- R11: While busy, writes to data, control and divider are ignored. A write to select takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 5 | Byte address of the register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Active-low slave selects |
| irq | output | 1 | Transfer-done interrupt |

## Verification
The end of a transfer can fall in the same cycle as a new control write that carries the start bit. The write is seen on the clock edge that clears busy, so it must be dropped. The bench times a write onto exactly that edge of a short transfer. It then expects no new transfer, SCLK held low, the old control fields in the readback and `irq` still set. The behavioural model judges the cycle by the busy state before the edge.

// File: rtl/spi_regmaster.sv
module spi_regmaster #(
  parameter int DIV_W = 16,
  parameter int NSS   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic [NSS-1:0]   ss_n,
  output logic             irq
);
  localparam int LEN_W  = 7;
  localparam int BITS   = 1 << LEN_W;
  localparam int EDGE_W = LEN_W + 2;
  localparam logic [LEN_W:0]    ONE_N = 1;
  localparam logic [EDGE_W-1:0] ONE_E = 1;

  logic [BITS-1:0]   field;
  logic [LEN_W-1:0]  len;
  logic              ss_gate, irq_en, lsb_first, drive_fall, sample_fall, busy;
  logic [DIV_W-1:0]  div, cnt;
  logic [NSS-1:0]    sel;
  logic [EDGE_W-1:0] edg;
  logic              sclk_q, mosi_q, irq_q;

  function automatic logic [LEN_W-1:0] bitpos(input logic [LEN_W:0] k,
                                               input logic [LEN_W:0] nb,
                                               input logic lf);
    logic [LEN_W:0] p;
    p = lf ? k : nb - ONE_N - k;
    return p[LEN_W-1:0];
  endfunction

  wire [2:0]       widx     = reg_addr[4:2];
  wire             wr_ok    = reg_wr && (!busy || widx == 3'd6);
  wire             go       = reg_wr && !busy && widx == 3'd4 && reg_wdata[8];
  wire [LEN_W:0]   nbits    = (len == '0) ? (LEN_W+1)'(BITS) : {1'b0, len};
  wire [LEN_W:0]   go_nbits = (reg_wdata[LEN_W-1:0] == '0) ? (LEN_W+1)'(BITS)
                                                            : {1'b0, reg_wdata[LEN_W-1:0]};
  wire             tick     = busy && cnt == '0;
  wire             last     = tick && edg == ({nbits, 1'b0} - ONE_E);
  wire [EDGE_W-1:0] edg_p1  = edg + ONE_E;
  wire [LEN_W:0]   rx_k     = edg[EDGE_W-1:1];
  wire [LEN_W:0]   tx_k     = drive_fall ? edg_p1[EDGE_W-1:1] : edg[EDGE_W-1:1];
  wire             do_rx    = tick && (edg[0] == sample_fall);
  wire             do_tx    = tick && (edg[0] == drive_fall) && tx_k < nbits;
  logic            unused_addr;
  assign unused_addr = ^reg_addr[1:0];

  always_comb begin
    case (widx)
      3'd0, 3'd1, 3'd2, 3'd3: reg_rdata = field[{widx[1:0], 5'd0} +: 32];
      3'd4: reg_rdata = {18'd0, ss_gate, irq_en, lsb_first, drive_fall, sample_fall,
                         busy, 1'b0, len};
      3'd5: reg_rdata = {{(32-DIV_W){1'b0}}, div};
      3'd6: reg_rdata = {{(32-NSS){1'b0}}, sel};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field <= '0;  len <= '0;  div <= '0;  cnt <= '0;  sel <= '0;  edg <= '0;
      ss_gate <= 1'b0;  irq_en <= 1'b0;  lsb_first <= 1'b0;
      drive_fall <= 1'b0;  sample_fall <= 1'b0;  busy <= 1'b0;
      sclk_q <= 1'b0;  mosi_q <= 1'b0;  irq_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (widx)
          3'd0, 3'd1, 3'd2, 3'd3: field[{widx[1:0], 5'd0} +: 32] <= reg_wdata;
          3'd4: begin
            len         <= reg_wdata[LEN_W-1:0];
            sample_fall <= reg_wdata[9];
            drive_fall  <= reg_wdata[10];
            lsb_first   <= reg_wdata[11];
            irq_en      <= reg_wdata[12];
            ss_gate     <= reg_wdata[13];
            irq_q       <= 1'b0;
          end
          3'd5: div <= reg_wdata[DIV_W-1:0];
          3'd6: sel <= reg_wdata[NSS-1:0];
          default: ;
        endcase
      end
      if (go) begin
        busy   <= 1'b1;
        cnt    <= div;
        edg    <= '0;
        sclk_q <= 1'b0;
        mosi_q <= field[bitpos('0, go_nbits, reg_wdata[11])];
      end
      if (busy) begin
        if (tick) begin
          cnt    <= div;
          sclk_q <= ~sclk_q;
          edg    <= edg_p1;
          if (do_rx) field[bitpos(rx_k, nbits, lsb_first)] <= miso;
          if (do_tx) mosi_q <= field[bitpos(tx_k, nbits, lsb_first)];
          if (last) begin
            busy   <= 1'b0;
            mosi_q <= 1'b0;
            irq_q  <= irq_q | irq_en;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign sclk = sclk_q;
  assign mosi = busy & mosi_q;
  assign irq  = irq_q;
  assign ss_n = ~(ss_gate ? (sel & {NSS{busy}}) : sel);

endmodule

// File: rtl/spi_regmaster_chk.sv
module spi_regmaster_chk #(
  parameter int DIV_W = 16,
  parameter int NSS   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             sclk,
  input logic             mosi,
  input logic [NSS-1:0]   ss_n,
  input logic             irq,
  input logic             ss_gate,
  input logic             irq_en,
  input logic [DIV_W-1:0] cnt,
  input logic [DIV_W-1:0] div,
  input logic             reg_wr,
  input logic [4:0]       reg_addr,
  input logic [31:0]      reg_wdata
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sclk); // R4
  AST_SCLK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) busy && cnt != '0 |=> $stable(sclk)); // R4
  AST_MOSI_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mosi); // R5
  AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n) reg_wr && !busy && reg_addr[4:2] == 3'd4 && reg_wdata[8] |=> busy); // R2
  AST_SS_GATED_IDLE: assert property (@(posedge clk) disable iff (!rst_n) ss_gate && !busy |-> ss_n == '1); // R9
  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) && irq_en |-> irq); // R10
  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) $past(busy) |-> $stable(div)); // R11
endmodule

bind spi_regmaster spi_regmaster_chk #(.DIV_W(DIV_W), .NSS(NSS)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
  .irq(irq), .ss_gate(ss_gate), .irq_en(irq_en), .cnt(cnt), .div(div),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/spi_regmaster_tb_top.sv
module spi_regmaster_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, miso = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sclk, mosi, irq;
  logic [7:0] ss_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_regmaster dut_i (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .ss_n(ss_n), .irq(irq));

  // behavioural reference model
  int cyc = 0, p0 = 0, N = 128, T = 0, m_div = 0;
  bit m_busy = 0, m_irq = 0, m_lsb = 0, m_tx = 0, m_rx = 0, m_ie = 0, m_ass = 0;
  bit [6:0] m_len = 0;
  bit [7:0] m_ss = 0;
  bit [127:0] m_data = '0, m_orig = '0, m_pat = '0;

  function automatic int mpos(input int k);
    return m_lsb ? k : N - 1 - k;
  endfunction

  function automatic logic [31:0] mctrl();
    return {18'd0, m_ass, m_ie, m_lsb, m_tx, m_rx, m_busy, 1'b0, m_len};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; m_busy = 0; m_irq = 0; m_lsb = 0; m_tx = 0; m_rx = 0; m_ie = 0;
      m_ass = 0; m_len = 0; m_ss = 0; m_div = 0; m_data = '0;
    end else begin
      bit busy_old;
      cyc++;
      busy_old = m_busy;
      if (m_busy && cyc - p0 == T) begin
        m_busy = 0;
        for (int k = 0; k < N; k++) m_data[mpos(k)] = m_pat[k];
        if (m_ie) m_irq = 1;
      end
      if (reg_wr && (!busy_old || reg_addr[4:2] == 3'd6)) begin
        case (reg_addr[4:2])
          3'd0, 3'd1, 3'd2, 3'd3: m_data[reg_addr[3:2]*32 +: 32] = reg_wdata;
          3'd4: begin
            m_len = reg_wdata[6:0]; m_rx = reg_wdata[9]; m_tx = reg_wdata[10];
            m_lsb = reg_wdata[11]; m_ie = reg_wdata[12]; m_ass = reg_wdata[13];
            m_irq = 0;
            if (reg_wdata[8]) begin
              m_busy = 1; p0 = cyc; m_orig = m_data;
              N = (m_len == 0) ? 128 : int'(m_len);
              T = 2 * N * (m_div + 1);
            end
          end
          3'd5: m_div = int'(reg_wdata[15:0]);
          3'd6: m_ss = reg_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  task automatic cmp1(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %b expected %b", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ed, b;
      logic e_sclk, e_mosi;
      logic [7:0] e_ss;
      ed = m_busy ? (cyc - p0) / (m_div + 1) : 0;
      e_sclk = m_busy ? ed[0] : 1'b0;
      if (m_tx) b = ed >> 1;
      else b = (ed == 0) ? 0 : (ed - 1) >> 1;
      e_mosi = m_busy ? m_orig[mpos(b)] : 1'b0;
      e_ss = ~(m_ass ? (m_busy ? m_ss : 8'h00) : m_ss);
      cmp1(sclk, e_sclk, "R4 sclk");
      cmp1(mosi, e_mosi, "R5 mosi");
      cmp1(irq, m_irq, "R10 irq");
      checks++;
      if (ss_n !== e_ss) begin
        fails++;
        $display("FAIL R9 ss_n at cycle %0d: got %h expected %h", cyc, ss_n, e_ss);
      end
      miso = m_busy ? m_pat[(ed >> 1) < N ? (ed >> 1) : N - 1] : 1'b0;
    end
  end

  task automatic wr(input int idx, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'(idx * 4); reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input int idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = 5'(idx * 4);
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s: reg %0d got %h expected %h", tag, idx, reg_rdata, exp);
    end
  endtask

  function automatic logic [31:0] cw(input int len, input bit go, input bit rxf,
      input bit txf, input bit lsb, input bit ie, input bit ass);
    return {18'd0, ass, ie, lsb, txf, rxf, go, 1'b0, 7'(len)};
  endfunction

  task automatic new_pat();
    m_pat = {$urandom, $urandom, $urandom, $urandom};
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
  endtask

  task automatic check_words(input string tag);
    for (int w = 0; w < 4; w++) rd_chk(w, m_data[w*32 +: 32], tag);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rd_chk(4, 32'h0, "R1 reset ctrl");
    rd_chk(6, 32'h0, "R1 reset select");
    rd_chk(7, 32'h0, "R1 unused index");

    wr(0, 32'hA5C3_1E77); wr(1, 32'h0123_4567); wr(2, 32'h89AB_CDEF); wr(3, 32'hF00D_BEEF);
    wr(5, 32'd1); wr(6, 32'h05);
    check_words("R1 data readback");
    rd_chk(5, 32'd1, "R1 divider readback");
    rd_chk(6, 32'h05, "R1 select readback");

    // A: 8 bits, MSB first, drive falling, sample rising, gated selects
    new_pat();
    wr(4, cw(8, 1, 0, 1, 0, 1, 1));
    rd_chk(4, mctrl(), "R2 busy bit while running");
    wr(5, 32'd7);
    wr(0, 32'h0);
    wr(4, cw(3, 1, 1, 0, 1, 0, 0));
    wr(6, 32'h03);
    wait_idle();
    check_words("R8 A reply in place R3");
    rd_chk(5, 32'd1, "R11 divider write ignored");
    rd_chk(6, 32'h03, "R11 select write taken");
    rd_chk(4, mctrl(), "R2 busy cleared R11 ctrl kept");

    // B: 13 bits, LSB first, drive rising, sample falling
    wr(5, 32'd0);
    new_pat();
    wr(4, cw(13, 1, 1, 0, 1, 0, 0));
    wait_idle();
    check_words("R7 R6 B lsb-first falling sample");

    // C: length 0 gives 128 bits, both edges rising
    new_pat();
    wr(4, cw(0, 1, 0, 0, 0, 1, 1));
    wait_idle();
    check_words("R3 C full 128-bit transfer");

    // D: 40 bits across words, both edges falling
    wr(5, 32'd2);
    new_pat();
    wr(4, cw(40, 1, 1, 1, 1, 0, 1));
    wait_idle();
    check_words("R6 R7 D multiword");

    // E: go write landing on the completion edge is dropped
    wr(5, 32'd0);
    new_pat();
    wr(4, cw(3, 1, 0, 1, 0, 1, 1));
    repeat (T - 2) @(negedge clk);
    wr(4, cw(9, 1, 1, 0, 1, 0, 0));
    repeat (4) @(negedge clk);
    rd_chk(4, mctrl(), "R11 go on completion edge ignored");
    check_words("R8 E reply");

    wr(4, cw(5, 0, 0, 0, 0, 0, 0));
    rd_chk(4, mctrl(), "R10 ctrl write clears irq");
    repeat (3) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(4ns * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule